// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits just after the PHY byte capture on the receive side of a MAC. It watches a byte stream with a valid qualifier and skips the preamble. It locks onto the start delimiter and then decodes the 14-byte header as the bytes go past. Frames whose destination address is neither the station's own address nor broadcast are discarded. So are frames whose EtherType is not IPv4 or ARP. Discarded frames produce no payload output.

Frames that are kept have their payload forwarded as a byte stream with first and last markers. The trailing four check bytes are held back and never forwarded. When the valid qualifier falls, the block reports whether the frame check sequence was good. A frame that is cut short inside its header is reported as short. A frame that starts with a byte outside the preamble is skipped whole. In every case the block returns to hunting for the next delimiter. Saturating counters record accepted frames, check failures and discarded frames.

Top module: `eth_rx_filter`

## Requirements
- R1: While `rx_valid` is high before a frame starts, bytes of 0x55 are skipped, and the frame header begins with the byte after the first 0xD5. A byte that is neither 0x55 nor 0xD5 in that phase causes the whole burst to be ignored until `rx_valid` goes low: no payload, no `frame_done`, and `drop_count` increments.
- R2: The six bytes after the delimiter are the destination address, sent most significant byte first (the first byte is compared with `local_mac[47:40]`). A frame is kept only if they equal `local_mac` or are all 0xFF.
- R3: Header bytes 13 and 14 after the delimiter form the EtherType, high byte first. 0x0800 sets `frame_kind` to 1 (IPv4) and 0x0806 sets it to 2 (ARP). Any other value discards the frame.
- R4: A discarded frame (foreign address or other EtherType) produces no `pay_valid` and no `frame_done`, and increments `drop_count` once.
- R5: For a kept frame, every byte after the 14-byte header except the final four appears on `pay_data` in order with `pay_valid`. `pay_first` marks the first such byte and `pay_last` marks the final one; a single-byte payload carries both.
- R6: At the end of a kept frame, `frame_ok` is high if the frame check sequence is correct (IEEE CRC-32 over the address, type and payload bytes, sent least significant byte first). Otherwise `frame_crc_bad` is high. `accept_count` or `crc_err_count` increments accordingly.
- R7: `frame_done` is a one-cycle pulse in the cycle after the first clock edge that samples `rx_valid` low. It coincides with `pay_last`.
- R8: If `rx_valid` falls before all 14 header bytes have arrived, `frame_done` pulses with `frame_short` high and `frame_ok` low, and `drop_count` increments.
- R9: After a discarded, short, malformed or bad-check frame, the next well-formed frame is received normally.
- R10: Each counter stops at its all-ones value and holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Station address compared with the destination field |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | High while a burst of bytes is present |
| pay_data | output | 8 | Forwarded payload byte |
| pay_valid | output | 1 | Payload byte present |
| pay_first | output | 1 | First payload byte of the frame |
| pay_last | output | 1 | Final payload byte of the frame |
| frame_kind | output | 2 | 0 none, 1 IPv4, 2 ARP for the current frame |
| frame_done | output | 1 | End-of-frame status strobe |
| frame_ok | output | 1 | Frame check passed |
| frame_crc_bad | output | 1 | Frame check failed |
| frame_short | output | 1 | Frame ended inside its header |
| accept_count | output | CNT_W | Frames accepted with good check |
| crc_err_count | output | CNT_W | Kept frames with bad check |
| drop_count | output | CNT_W | Filtered, short or malformed frames |

## Verification
The hardest situation to reach is the frame's end: the final payload byte must carry its last marker together with the status strobe. Yet the block learns where the payload ended only when `rx_valid` falls, four check bytes later. The bench builds frames with a check sequence computed on its own, ending exactly after the check bytes. It samples the outputs in the single cycle after `rx_valid` is seen low, with payload lengths of one, ten and forty-six bytes. Truncation inside the header and a foreign byte inside the preamble are also produced. Each is followed directly by a good frame to show that the block recovers.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [7:0]  PRE_BYTE    = 8'h55;
    localparam logic [7:0]  SFD_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
    // Fixed remainder of a good frame, reflected-register form of 0xC704DD7B
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;
    localparam logic [15:0] TYPE_IPV4   = 16'h0800;
    localparam logic [15:0] TYPE_ARP    = 16'h0806;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2,
        ST_SKIP = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_IPV4 = 2'd1,
        KIND_ARP  = 2'd2
    } kind_e;

endpackage

// File: rtl/rxf_crc32.sv
module rxf_crc32
    import rxf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [31:0]   crc
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        logic [31:0] c;
        c = crc_q;
        if (clear) begin
            c = '1;
        end else if (en) begin
            for (int i = 0; i < DW; i++) begin
                c = (c >> 1) ^ (CRC_POLY_R & {32{c[0] ^ din[i]}});
            end
        end
        crc_d = c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/rxf_tail_hold.sv
module rxf_tail_hold #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         rel_valid,
    output logic [W-1:0] rel_data,
    output logic         pend_valid,
    output logic [W-1:0] pend_data
);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] sh;
        logic [FW-1:0]           fill;
        logic                    pv;
        logic [W-1:0]            pend;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (flush) begin
            d.fill = '0;
            d.pv   = 1'b0;
        end else if (push) begin
            d.sh = {q.sh[DEPTH-2:0], din};
            if (q.fill == FULL) begin
                d.pend = q.sh[DEPTH-1];
                d.pv   = 1'b1;
            end else begin
                d.fill = q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rel_valid  = push && !flush && q.pv;
    assign rel_data   = q.pend;
    assign pend_valid = q.pv;
    assign pend_data  = q.pend;

    p_pend_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv |-> (q.fill == FULL));
endmodule

// File: rtl/rxf_sat_cnt.sv
module rxf_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q == TOP) |=> (cnt_q == TOP));
    p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import rxf_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FCS_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [47:0]      local_mac,
    input  logic [7:0]       rx_data,
    input  logic             rx_valid,
    output logic [7:0]       pay_data,
    output logic             pay_valid,
    output logic             pay_first,
    output logic             pay_last,
    output logic [1:0]       frame_kind,
    output logic             frame_done,
    output logic             frame_ok,
    output logic             frame_crc_bad,
    output logic             frame_short,
    output logic [CNT_W-1:0] accept_count,
    output logic [CNT_W-1:0] crc_err_count,
    output logic [CNT_W-1:0] drop_count
);
    localparam int ADDR_BYTES = 6;
    localparam int HDR_BYTES  = 14;
    localparam int IDX_W      = $clog2(HDR_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_ADDR_END = IDX_W'(ADDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_TYPE_HI  = IDX_W'(HDR_BYTES - 2);
    localparam logic [IDX_W-1:0] IDX_TYPE_LO  = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_ADDR_LIM = IDX_W'(ADDR_BYTES);
    localparam int N_CNT    = 3;
    localparam int IDX_ACC  = 0;
    localparam int IDX_CRC  = 1;
    localparam int IDX_DROP = 2;

    typedef struct packed {
        rx_state_e        st;
        logic [IDX_W-1:0] hdr_idx;
        logic             hit_local;
        logic             hit_bcast;
        logic [7:0]       type_hi;
        kind_e            kind;
        logic             first_pend;
        logic [7:0]       pay_data;
        logic             pay_valid;
        logic             pay_first;
        logic             pay_last;
        logic             done;
        logic             ok;
        logic             crc_bad;
        logic             short_f;
    } rx_t;

    rx_t d, q;

    logic             crc_clear, crc_en;
    logic [31:0]      crc_val;
    logic             hold_push, hold_flush;
    logic             rel_valid, pend_valid;
    logic [7:0]       rel_data, pend_data;
    logic [N_CNT-1:0] cnt_inc;
    logic [47:0]      mac_sh;
    logic [7:0]       mac_byte;
    logic             crc_ok;

    assign mac_sh   = local_mac << {q.hdr_idx, 3'b000};
    assign mac_byte = mac_sh[47:40];
    assign crc_ok   = (crc_val == CRC_RESIDUE);

    rxf_crc32 #(.DW(8)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .en    (crc_en),
        .din   (rx_data),
        .crc   (crc_val)
    );

    rxf_tail_hold #(.W(8), .DEPTH(FCS_BYTES)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (hold_flush),
        .push       (hold_push),
        .din        (rx_data),
        .rel_valid  (rel_valid),
        .rel_data   (rel_data),
        .pend_valid (pend_valid),
        .pend_data  (pend_data)
    );

    logic [CNT_W-1:0] cnt_val [N_CNT];

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        rxf_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    always_comb begin
        d = q;
        d.pay_valid = 1'b0;
        d.pay_first = 1'b0;
        d.pay_last  = 1'b0;
        d.done      = 1'b0;
        d.ok        = 1'b0;
        d.crc_bad   = 1'b0;
        d.short_f   = 1'b0;
        cnt_inc     = '0;
        crc_clear   = 1'b0;
        crc_en      = 1'b0;
        hold_push   = 1'b0;
        hold_flush  = 1'b0;

        case (q.st)
            ST_HUNT: begin
                if (rx_valid) begin
                    if (rx_data == SFD_BYTE) begin
                        d.st         = ST_HDR;
                        d.hdr_idx    = '0;
                        d.hit_local  = 1'b1;
                        d.hit_bcast  = 1'b1;
                        d.kind       = KIND_NONE;
                        d.first_pend = 1'b1;
                        crc_clear    = 1'b1;
                        hold_flush   = 1'b1;
                    end else if (rx_data != PRE_BYTE) begin
                        d.st              = ST_SKIP;
                        cnt_inc[IDX_DROP] = 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (!rx_valid) begin
                    d.st              = ST_HUNT;
                    d.done            = 1'b1;
                    d.short_f         = 1'b1;
                    cnt_inc[IDX_DROP] = 1'b1;
                end else begin
                    crc_en    = 1'b1;
                    d.hdr_idx = q.hdr_idx + 1'b1;
                    if (q.hdr_idx < IDX_ADDR_LIM) begin
                        d.hit_local = q.hit_local && (rx_data == mac_byte);
                        d.hit_bcast = q.hit_bcast && (rx_data == 8'hFF);
                        if (q.hdr_idx == IDX_ADDR_END && !d.hit_local && !d.hit_bcast) begin
                            d.st              = ST_SKIP;
                            cnt_inc[IDX_DROP] = 1'b1;
                        end
                    end
                    if (q.hdr_idx == IDX_TYPE_HI) d.type_hi = rx_data;
                    if (q.hdr_idx == IDX_TYPE_LO) begin
                        if ({q.type_hi, rx_data} == TYPE_IPV4) begin
                            d.kind = KIND_IPV4;
                            d.st   = ST_BODY;
                        end else if ({q.type_hi, rx_data} == TYPE_ARP) begin
                            d.kind = KIND_ARP;
                            d.st   = ST_BODY;
                        end else begin
                            d.st              = ST_SKIP;
                            cnt_inc[IDX_DROP] = 1'b1;
                        end
                    end
                end
            end
            ST_BODY: begin
                if (rx_valid) begin
                    crc_en    = 1'b1;
                    hold_push = 1'b1;
                    if (rel_valid) begin
                        d.pay_valid  = 1'b1;
                        d.pay_data   = rel_data;
                        d.pay_first  = q.first_pend;
                        d.first_pend = 1'b0;
                    end
                end else begin
                    d.st      = ST_HUNT;
                    d.done    = 1'b1;
                    d.ok      = crc_ok;
                    d.crc_bad = !crc_ok;
                    if (crc_ok) cnt_inc[IDX_ACC] = 1'b1;
                    else        cnt_inc[IDX_CRC] = 1'b1;
                    if (pend_valid) begin
                        d.pay_valid  = 1'b1;
                        d.pay_data   = pend_data;
                        d.pay_first  = q.first_pend;
                        d.pay_last   = 1'b1;
                        d.first_pend = 1'b0;
                    end
                end
            end
            ST_SKIP: begin
                if (!rx_valid) d.st = ST_HUNT;
            end
            default: d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pay_data      = q.pay_data;
    assign pay_valid     = q.pay_valid;
    assign pay_first     = q.pay_first;
    assign pay_last      = q.pay_last;
    assign frame_kind    = q.kind;
    assign frame_done    = q.done;
    assign frame_ok      = q.ok;
    assign frame_crc_bad = q.crc_bad;
    assign frame_short   = q.short_f;
    assign accept_count  = cnt_val[IDX_ACC];
    assign crc_err_count = cnt_val[IDX_CRC];
    assign drop_count    = cnt_val[IDX_DROP];

    p_last_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.pay_last |-> q.done);
    p_one_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($countones({q.ok, q.crc_bad, q.short_f}) == 1));
    p_status_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> !(q.ok || q.crc_bad || q.short_f));
    p_marker_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pay_first || q.pay_last) |-> q.pay_valid);
    p_kind_in_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BODY) |-> (q.kind != KIND_NONE));
    p_short_from_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.short_f |-> ($past(q.st) == ST_HDR));
    p_skip_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> (!q.pay_valid && !q.done));
endmodule

// File: tb/eth_rx_filter_bench.sv
module eth_rx_filter_bench;
    localparam int CW = 3;
    localparam logic [47:0] MY_MAC = 48'h02_1A_2B_3C_4D_5E;
    localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [47:0]   local_mac = MY_MAC;
    logic [7:0]    rx_data = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    pay_data;
    logic          pay_valid, pay_first, pay_last;
    logic [1:0]    frame_kind;
    logic          frame_done, frame_ok, frame_crc_bad, frame_short;
    logic [CW-1:0] accept_count, crc_err_count, drop_count;

    always #5 clk = ~clk;

    eth_rx_filter #(.CNT_W(CW)) u_eth_rx_filter (
        .clk(clk), .rst_n(rst_n), .local_mac(local_mac),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_first(pay_first), .pay_last(pay_last),
        .frame_kind(frame_kind), .frame_done(frame_done), .frame_ok(frame_ok),
        .frame_crc_bad(frame_crc_bad), .frame_short(frame_short),
        .accept_count(accept_count), .crc_err_count(crc_err_count), .drop_count(drop_count)
    );

    int checks = 0;
    int errors = 0;
    int exp_acc = 0, exp_crc = 0, exp_drop = 0;
    bit finished = 1'b0;

    logic [7:0] frm [0:127];
    int flen;

    logic [7:0] cap [0:127];
    int cap_n, first_n, last_n, first_idx, last_idx, done_n;

    logic e_done, e_ok, e_bad, e_short, e_last;
    logic [7:0] e_data;

    always @(negedge clk) begin
        if (pay_valid) begin
            if (pay_first) begin first_n++; first_idx = cap_n; end
            if (pay_last)  begin last_n++;  last_idx  = cap_n; end
            if (cap_n < 128) cap[cap_n] = pay_data;
            cap_n++;
        end
        if (frame_done) done_n++;
    end

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > (2**CW - 1)) ? (2**CW - 1) : v;
    endfunction

    task automatic check_counts(input string tag);
        check(accept_count == CW'(sat(exp_acc)), {tag, " R10 accept_count"}, accept_count, sat(exp_acc));
        check(crc_err_count == CW'(sat(exp_crc)), {tag, " R6 crc_err_count"}, crc_err_count, sat(exp_crc));
        check(drop_count == CW'(sat(exp_drop)), {tag, " R4 drop_count"}, drop_count, sat(exp_drop));
    endtask

    task automatic put(input logic [7:0] b);
        frm[flen] = b;
        flen++;
    endtask

    task automatic build(input logic [47:0] dst, input logic [15:0] et,
                         input int plen, input logic [7:0] seed);
        logic [31:0] c;
        flen = 0;
        for (int i = 0; i < 7; i++) put(8'h55);
        put(8'hD5);
        for (int i = 5; i >= 0; i--) put(dst[i*8 +: 8]);
        for (int i = 0; i < 6; i++) put(8'h70 + 8'(i));
        put(et[15:8]);
        put(et[7:0]);
        for (int i = 0; i < plen; i++) put(seed + 8'(i));
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < flen; i++) begin
            c = c ^ {24'h0, frm[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) put(c[i*8 +: 8]);
    endtask

    // drives frm[0 .. cut-1], drops rx_valid, samples the cycle after the low is seen
    task automatic send(input int cut);
        cap_n = 0; first_n = 0; last_n = 0; done_n = 0; first_idx = -1; last_idx = -1;
        for (int i = 0; i < cut; i++) begin
            @(posedge clk); #1;
            rx_data = frm[i];
            rx_valid = 1'b1;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
        rx_data = 8'h00;
        @(posedge clk);
        @(negedge clk);
        e_done = frame_done; e_ok = frame_ok; e_bad = frame_crc_bad;
        e_short = frame_short; e_last = pay_last; e_data = pay_data;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_good(input string tag, input int plen, input logic [7:0] seed,
                              input logic [1:0] kind);
        check(e_done == 1'b1, {tag, " R7 done after fall"}, e_done, 1);
        check(e_ok == 1'b1 && e_bad == 1'b0, {tag, " R6 fcs ok"}, {e_ok, e_bad}, 2);
        check(e_last == 1'b1, {tag, " R7 last with done"}, e_last, 1);
        check(e_data == seed + 8'(plen - 1), {tag, " R5 last byte"}, e_data, seed + 8'(plen - 1));
        check(cap_n == plen, {tag, " R5 payload length"}, cap_n, plen);
        for (int i = 0; i < plen && i < 128; i++) begin
            if (cap[i] != seed + 8'(i)) begin
                check(1'b0, {tag, " R5 payload byte"}, cap[i], seed + 8'(i));
                break;
            end
        end
        check(first_n == 1 && first_idx == 0, {tag, " R5 first marker"}, first_idx, 0);
        check(last_n == 1 && last_idx == plen - 1, {tag, " R5 last marker"}, last_idx, plen - 1);
        check(frame_kind == kind, {tag, " R3 kind"}, frame_kind, kind);
        check(done_n == 1, {tag, " R7 single done pulse"}, done_n, 1);
    endtask

    task automatic t_reset();
        check(pay_valid == 0 && frame_done == 0, "reset R7 outputs idle", {pay_valid, frame_done}, 0);
        check(frame_kind == 2'd0, "reset R3 kind none", frame_kind, 0);
        check_counts("reset");
    endtask

    task automatic t_unicast_ipv4();
        build(MY_MAC, 16'h0800, 10, 8'h10);
        send(flen);
        exp_acc++;
        check_good("unicast R2", 10, 8'h10, 2'd1);
        check_counts("unicast");
    endtask

    task automatic t_bcast_arp();
        build(BCAST, 16'h0806, 46, 8'hA0);
        send(flen);
        exp_acc++;
        check_good("broadcast R2", 46, 8'hA0, 2'd2);
        check_counts("broadcast");
    endtask

    task automatic t_foreign_addr();
        build(48'h02_1A_2B_3C_4D_5F, 16'h0800, 12, 8'h33);
        send(flen);
        exp_drop++;
        check(cap_n == 0, "foreign R2 no payload", cap_n, 0);
        check(done_n == 0, "foreign R4 no done", done_n, 0);
        check_counts("foreign");
    endtask

    task automatic t_other_type();
        build(MY_MAC, 16'h86DD, 12, 8'h44);
        send(flen);
        exp_drop++;
        check(cap_n == 0, "other-type R3 no payload", cap_n, 0);
        check(done_n == 0, "other-type R4 no done", done_n, 0);
        check_counts("other-type");
    endtask

    task automatic t_bad_fcs();
        build(MY_MAC, 16'h0800, 20, 8'h50);
        frm[8 + 14 + 3] = frm[8 + 14 + 3] ^ 8'h01;
        send(flen);
        exp_crc++;
        check(e_done == 1'b1 && e_bad == 1'b1 && e_ok == 1'b0, "bad-fcs R6 flagged",
              {e_done, e_ok, e_bad}, 3'b101);
        check(cap_n == 20, "bad-fcs R5 payload count", cap_n, 20);
        check_counts("bad-fcs");
    endtask

    task automatic t_truncated();
        build(MY_MAC, 16'h0800, 10, 8'h60);
        send(8 + 9);
        exp_drop++;
        check(e_done == 1'b1 && e_short == 1'b1 && e_ok == 1'b0, "truncated R8 short flag",
              {e_done, e_ok, e_short}, 3'b101);
        check(cap_n == 0, "truncated R8 no payload", cap_n, 0);
        check_counts("truncated");
        build(MY_MAC, 16'h0806, 8, 8'h68);
        send(flen);
        exp_acc++;
        check_good("after-truncated R9", 8, 8'h68, 2'd2);
        check_counts("after-truncated");
    endtask

    task automatic t_bad_preamble();
        build(MY_MAC, 16'h0800, 10, 8'h80);
        frm[3] = 8'h12;
        send(flen);
        exp_drop++;
        check(cap_n == 0 && done_n == 0, "bad-preamble R1 burst ignored", {cap_n, done_n}, 0);
        check_counts("bad-preamble");
        build(MY_MAC, 16'h0800, 5, 8'h90);
        send(flen);
        exp_acc++;
        check_good("after-preamble R9", 5, 8'h90, 2'd1);
    endtask

    task automatic t_saturate();
        for (int n = 0; n < 5; n++) begin
            build(BCAST, 16'h0800, 1, 8'hC0 + 8'(n));
            send(flen);
            exp_acc++;
            if (n == 0) begin
                check(first_n == 1 && last_n == 1 && cap_n == 1, "one-byte R5 both markers",
                      {first_n, last_n}, 2);
                check(e_last == 1'b1 && e_ok == 1'b1, "one-byte R7 last and ok", {e_last, e_ok}, 3);
            end
        end
        check(accept_count == '1, "saturate R10 accept at all-ones", accept_count, 2**CW - 1);
        check_counts("saturate");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast_ipv4();
        t_bcast_arp();
        t_foreign_addr();
        t_other_type();
        t_bad_fcs();
        t_truncated();
        t_bad_preamble();
        t_saturate();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule